// File: doc/BRIEF.md
# Carrier Preamble Wake-Up Detector

This block watches the sliced, demodulated data bit of a low-power receiver and tells downstream logic that a transmission is starting. A transmitter opens each burst with an unbroken carrier; once the carrier has been seen continuously for long enough, the block pulls an active-low wake flag low. The flag stays low for as long as the carrier stays up and is released at the first sampled low level, which marks the start of data modulation.

The block runs from the receiver reference clock. An internal prescaler divides that clock down to a slow sampling tick (divide-by-256 by default, roughly 23 kHz from a 6 MHz reference), and a resettable run-length counter counts ticks on which the synchronized carrier is high. The default terminal count of 128 ticks corresponds to about 5 ms of carrier. A shutdown request disables the function: the counter is held at zero, the flag is held inactive and the prescaler restarts from zero when shutdown is released, so tick timing after wake-up is exactly repeatable. The current run length is brought out as a debug count.

Top module: `carrier_wake_detect`

## Requirements
- R1: While `rst` is high at a rising clock edge, `wake_n` is 1 and `dbg_count` is 0 after that edge, whatever `shutdown` and `carrier_in` do.
- R2: With `shutdown` released just before edge 0, the sampling tick is consumed on edges PRESCALE_DIV, 2*PRESCALE_DIV, ...; `dbg_count` changes only on those edges and is 0 after edges 0 to PRESCALE_DIV-1.
- R3: `carrier_in` passes through SYNC_STAGES flops and is read only at tick edges; a low pulse of one clock that does not cover a sampled position leaves `dbg_count` unchanged.
- R4: After RUN_TICKS consecutive high samples `dbg_count` equals RUN_TICKS on that tick edge, and `wake_n` falls on the following edge.
- R5: A low sample before the run completes sets `dbg_count` to 0 on that tick edge.
- R6: `dbg_count` saturates at RUN_TICKS while high samples continue, and `wake_n` stays 0.
- R7: With `wake_n` at 0, the first low sample sets `wake_n` to 1 and `dbg_count` to 0 on the same tick edge; a new detection needs a fresh run of RUN_TICKS high samples.
- R8: While `shutdown` is 1 at an edge, `wake_n` is 1 and `dbg_count` is 0 after it; shutdown takes priority over a tick arriving at the same edge.
- R9: Releasing `shutdown` restarts the prescaler from zero, so the first count after release lands exactly PRESCALE_DIV edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver reference clock |
| rst | input | 1 | Synchronous reset, active high |
| shutdown | input | 1 | Shutdown request, active high; disables detection |
| carrier_in | input | 1 | Sliced demodulated data bit, 1 = carrier present |
| wake_n | output | 1 | Wake flag, active low |
| dbg_count | output | $clog2(RUN_TICKS+1) | Current run length in sampling ticks |

## Verification
The interesting collision is a shutdown request landing on the very edge at which a sampling tick would advance the run counter. The bench releases shutdown with the carrier up, lets the prescaler run to the edge just before a tick is consumed and raises shutdown on that cycle; the count must read 0 after that edge rather than one more, and the wake flag must never fall on the next edge. A second coincidence, the first low sample arriving while the count is saturated, is judged by requiring flag release and counter clear on the same edge.

// File: rtl/wake_pkg.sv
package wake_pkg;

  // State of the wake flag: idle (no header detected) or awake.
  typedef enum logic {
    FLAG_IDLE  = 1'b0,
    FLAG_AWAKE = 1'b1
  } flag_state_t;

  // Width needed to hold values 0..max_val inclusive.
  function automatic int count_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/wake_sync.sv
// Multi-stage synchronizer for the asynchronous carrier bit.
module wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("wake_sync: STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain <= {chain[STAGES-2:0], d_i};
    end
  end

  assign q_o = chain[LAST];

endmodule

// File: rtl/wake_prescaler.sv
// Divides the reference clock into a one-cycle sampling tick.
// The divider is held at zero during shutdown so that timing after
// release is deterministic.
module wake_prescaler #(
  parameter int DIV = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic tick_o
);

  localparam int PW = (DIV < 2) ? 1 : $clog2(DIV);
  localparam logic [PW-1:0] LAST_VAL = PW'(DIV - 1);

  logic [PW-1:0] div_cnt;
  logic          tick_q;
  logic          wrap;

  generate
    if (DIV < 2) begin : g_bad
      initial $error("wake_prescaler: DIV must be at least 2");
    end
  endgenerate

  assign wrap = (div_cnt == LAST_VAL);

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      div_cnt <= '0;
      tick_q  <= 1'b0;
    end else begin
      div_cnt <= wrap ? '0 : div_cnt + 1'b1;
      tick_q  <= wrap;
    end
  end

  assign tick_o = tick_q;

  // A tick is never followed directly by another tick.
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);

  // Shutdown returns the divider to its start point.
  assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (div_cnt == '0 && !tick_q));

endmodule

// File: rtl/wake_runlen.sv
// Resettable, saturating run-length counter of high carrier samples.
module wake_runlen #(
  parameter int RUN_TICKS = 128,
  parameter int CW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_i,
  input  logic          tick_i,
  input  logic          carrier_i,
  output logic [CW-1:0] run_o
);

  localparam logic [CW-1:0] TOP = CW'(RUN_TICKS);

  logic [CW-1:0] run_q;
  logic          at_top;

  assign at_top = (run_q == TOP);

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      run_q <= '0;
    end else if (tick_i) begin
      if (!carrier_i) begin
        run_q <= '0;
      end else if (!at_top) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign run_o = run_q;

  // Count moves only on tick edges.
  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !hold_i) |=> $stable(run_q));

  // A low sample clears the run.
  assert_clear_on_gap_R5: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !carrier_i) |=> (run_q == '0));

  // Saturation: terminal value survives further high samples.
  assert_saturate_R6: assert property (@(posedge clk) disable iff (rst)
    (at_top && tick_i && carrier_i && !hold_i) |=> (run_q == TOP));

endmodule

// File: rtl/wake_flag.sv
// Holds the wake flag from a completed run until the first low sample.
module wake_flag
  import wake_pkg::*;
#(
  parameter int RUN_TICKS = 128,
  parameter int CW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_i,
  input  logic          tick_i,
  input  logic          carrier_i,
  input  logic [CW-1:0] run_i,
  output logic          wake_n_o
);

  localparam logic [CW-1:0] TOP = CW'(RUN_TICKS);

  flag_state_t state_q;
  flag_state_t state_d;

  always_comb begin
    state_d = state_q;
    if (tick_i && !carrier_i) begin
      state_d = FLAG_IDLE;
    end else if (run_i == TOP) begin
      state_d = FLAG_AWAKE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      state_q <= FLAG_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign wake_n_o = (state_q != FLAG_AWAKE);

  // The flag only falls right after the run has reached its terminal count.
  assert_wake_after_run_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(wake_n_o) |-> ($past(run_i) == TOP));

  // First low sample while awake releases the flag.
  assert_release_on_data_R7: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !carrier_i && !wake_n_o) |=> wake_n_o);

endmodule

// File: rtl/carrier_wake_detect.sv
// Carrier preamble wake-up detector, top level.
module carrier_wake_detect
  import wake_pkg::*;
#(
  parameter int PRESCALE_DIV = 256,
  parameter int RUN_TICKS    = 128,
  parameter int SYNC_STAGES  = 2,
  localparam int CW          = count_width(RUN_TICKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shutdown,
  input  logic          carrier_in,
  output logic          wake_n,
  output logic [CW-1:0] dbg_count
);

  logic carrier_s;
  logic tick;
  logic [CW-1:0] run_cnt;

  wake_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (carrier_in),
    .q_o (carrier_s)
  );

  wake_prescaler #(
    .DIV (PRESCALE_DIV)
  ) u_prescale (
    .clk    (clk),
    .rst    (rst),
    .hold_i (shutdown),
    .tick_o (tick)
  );

  wake_runlen #(
    .RUN_TICKS (RUN_TICKS),
    .CW        (CW)
  ) u_runlen (
    .clk       (clk),
    .rst       (rst),
    .hold_i    (shutdown),
    .tick_i    (tick),
    .carrier_i (carrier_s),
    .run_o     (run_cnt)
  );

  wake_flag #(
    .RUN_TICKS (RUN_TICKS),
    .CW        (CW)
  ) u_flag (
    .clk       (clk),
    .rst       (rst),
    .hold_i    (shutdown),
    .tick_i    (tick),
    .carrier_i (carrier_s),
    .run_i     (run_cnt),
    .wake_n_o  (wake_n)
  );

  assign dbg_count = run_cnt;

  // Reset state seen at the ports.
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (wake_n && dbg_count == '0));

  // Shutdown forces the inactive state on the next edge.
  assert_shutdown_idle_R8: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> (wake_n && dbg_count == '0));

  // Count never exceeds its terminal value.
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    dbg_count <= CW'(RUN_TICKS));

endmodule

// File: tb/carrier_wake_detect_tb.sv
module carrier_wake_detect_tb;

  localparam int DIV = 4;
  localparam int RUN = 8;
  localparam int CW  = $clog2(RUN + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          shutdown = 1'b0;
  logic          carrier_in = 1'b1;
  logic          wake_n;
  logic [CW-1:0] dbg_count;

  always #10 clk = ~clk;   // 50 MHz

  carrier_wake_detect #(
    .PRESCALE_DIV (DIV),
    .RUN_TICKS    (RUN),
    .SYNC_STAGES  (2)
  ) u_dut (
    .clk        (clk),
    .rst        (rst),
    .shutdown   (shutdown),
    .carrier_in (carrier_in),
    .wake_n     (wake_n),
    .dbg_count  (dbg_count)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    logic  wn;
    int    cnt;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  int   base   = 0;

  // Edge j after the last shutdown release.
  function automatic int E(input int j);
    return base + 1 + j;
  endfunction

  task automatic expect_at(input int at, input logic wn, input int cnt, input string tag);
    exp_t e;
    e.at = at; e.wn = wn; e.cnt = cnt; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor: pops expectations at the cycle they are due.
  always @(negedge clk) begin
    exp_t e;
    while (q.size() > 0 && q[0].at <= cyc) begin
      e = q.pop_front();
      checks++;
      if (e.at != cyc || wake_n !== e.wn || dbg_count !== CW'(e.cnt)) begin
        fails++;
        $display("FAIL %s at cyc %0d (due %0d): wake_n=%b dbg_count=%0d expected wake_n=%b dbg_count=%0d",
                 e.tag, cyc, e.at, wake_n, dbg_count, e.wn, e.cnt);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (R1..R9 unfinished): actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // Driver
  initial begin
    // R1: reset with active inputs
    @(negedge clk);
    wait_cyc(4);
    expect_at(cyc + 1, 1'b1, 0, "R1 reset state");
    expect_at(cyc + 2, 1'b1, 0, "R1 reset state held");
    wait_cyc(6);
    shutdown = 1'b1;
    rst = 1'b0;
    // R8: shutdown holds with carrier present
    expect_at(cyc + 10, 1'b1, 0, "R8 shutdown holds idle");
    expect_at(cyc + 30, 1'b1, 0, "R8 shutdown holds idle late");
    wait_cyc(cyc + 40);

    // First release
    shutdown = 1'b0;
    base = cyc;
    expect_at(E(3), 1'b1, 0, "R2 no count before first tick");
    for (int k = 1; k <= RUN; k++) begin
      if (k >= 2) expect_at(E(DIV*k - 1), 1'b1, k - 1, "R2 count stable between ticks");
      expect_at(E(DIV*k), 1'b1, k, "R2 count on tick edge");
    end
    expect_at(E(DIV*RUN + 1), 1'b0, RUN, "R4 wake after full run");
    for (int k = RUN + 1; k <= 12; k++)
      expect_at(E(DIV*k), 1'b0, RUN, "R6 saturate and stay awake");

    // R7: data begins
    wait_cyc(E(48));
    carrier_in = 1'b0;
    expect_at(E(51), 1'b0, RUN, "R7 flag held until sampled low");
    expect_at(E(52), 1'b1, 0, "R7 flag released with count clear");

    // R5: interrupted run
    wait_cyc(E(52));
    carrier_in = 1'b1;
    for (int k = 14; k <= 18; k++)
      expect_at(E(DIV*k), 1'b1, k - 13, "R5 partial run counts");
    wait_cyc(E(72));
    carrier_in = 1'b0;
    expect_at(E(76), 1'b1, 0, "R5 gap clears count");
    wait_cyc(E(76));
    carrier_in = 1'b1;
    expect_at(E(84), 1'b1, 2, "R7 fresh run counting");

    // R3: one-cycle low pulse between sampled positions
    wait_cyc(E(84));
    carrier_in = 1'b0;
    wait_cyc(E(85));
    carrier_in = 1'b1;
    expect_at(E(88), 1'b1, 3, "R3 short gap ignored");
    expect_at(E(108), 1'b1, RUN, "R7 fresh run complete");
    expect_at(E(109), 1'b0, RUN, "R7 wake again after fresh run");

    // R8: shutdown while awake
    wait_cyc(E(112));
    shutdown = 1'b1;
    expect_at(E(113), 1'b1, 0, "R8 shutdown clears wake");
    wait_cyc(E(120));

    // R9: second release, then shutdown on a tick edge
    shutdown = 1'b0;
    base = cyc;
    expect_at(E(3), 1'b1, 0, "R9 prescaler restarted");
    expect_at(E(4), 1'b1, 1, "R9 first count after restart");
    expect_at(E(28), 1'b1, 7, "R9 count before collision");
    wait_cyc(E(31));
    shutdown = 1'b1;
    expect_at(E(32), 1'b1, 0, "R8 shutdown beats tick");
    expect_at(E(33), 1'b1, 0, "R8 no wake after collision");
    wait_cyc(E(40));

    // Third release: full detection again
    shutdown = 1'b0;
    base = cyc;
    expect_at(E(4), 1'b1, 1, "R9 deterministic first tick");
    expect_at(E(32), 1'b1, RUN, "R4 run complete");
    expect_at(E(33), 1'b0, RUN, "R4 wake falls next edge");
    wait_cyc(E(36));

    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule